// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block is a watchdog that counts timebase ticks, nominally one per microsecond, supplied as a single-cycle enable pulse from an external prescaler. A 4-bit period code picks one of sixteen timeout periods that are not evenly spaced, from 512 µs up to 64 s. Software keeps the watchdog quiet by writing a clear-counter strobe before the selected period runs out. If the count reaches the period, a sticky timeout flag is set. Depending on the enables that were written, the block then also drives a board-fail line and sends a one-cycle reset request to a local target or a system-wide target.

Configuration arrives as a single write strobe with a 16-bit data word. Each write updates every stored field. The two strobe bits in the word act only in the cycle of the write and are not stored. The decoded limit and the running count are brought out so that the surrounding logic can observe them.

Top module: `wdog_sel_period`

## Requirements
- R1: After reset the block is disabled, the period code is 0, and timeout_o, board_fail_o, rst_local_o, rst_sys_o and count_o are all 0.
- R2: Bits [3:0] of the write word store the period code. limit_o equals the period in microseconds times TICKS_PER_US. The codes 0 to 15 give 512, 1000, 2000, 4000, 8000, 16000, 32000, 64000, 128000, 256000, 512000, 1000000, 4000000, 16000000, 32000000 and 64000000 µs.
- R3: Bit 4 is the run enable. While it is stored as 0, count_o is held at 0, ticks are ignored and no timeout can occur. While it is 1, count_o rises by one on each cycle in which tick_i is high.
- R4: After exactly limit_o ticks counted from 0, timeout_o goes to 1 on the clock edge of the last tick, and count_o returns to 0 and keeps counting.
- R5: A write with bit 9 set, or a write whose period code differs from the stored one, clears count_o to 0 in that cycle, even when tick_i is high. A write that does neither leaves the count running.
- R6: On a timeout with bit 5 (reset enable) stored as 1, exactly one of rst_local_o (bit 6 = 0) or rst_sys_o (bit 6 = 1) pulses high for one cycle. With bit 5 at 0, neither one pulses.
- R7: On a timeout with bit 7 (fail enable) stored as 1, board_fail_o goes high and stays high until the status is cleared. With bit 7 at 0, board_fail_o stays low.
- R8: A write with bit 8 set clears timeout_o and board_fail_o. If a timeout occurs in the same cycle, the timeout wins and the flag stays set.
- R9: count_o is always below limit_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase enable pulse |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Write word: code [3:0], run 4, reset enable 5, scope 6, fail enable 7, clear status 8, clear count 9 |
| timeout_o | output | 1 | Sticky timeout flag |
| board_fail_o | output | 1 | Board-fail line |
| rst_local_o | output | 1 | One-cycle local reset request |
| rst_sys_o | output | 1 | One-cycle system reset request |
| count_o | output | CNT_W | Current watchdog count |
| limit_o | output | CNT_W | Decoded limit in ticks |

## Verification
Several properties are checked on every cycle. The count stays below the limit and is held at zero while the block is disabled. A reset request lasts one cycle and never goes to both targets at once. Board fail implies the flag, and the flag stays set until it is cleared. Other behaviour can only be shown by the bench's scenarios. These include the exact tick at which a timeout fires, the decode of all sixteen periods, the restart on a change of period, the routing of the scope bit, and the case where a timeout and a status clear land in the same cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int CFG_W      = 16;
   localparam int CODE_W     = 4;
   localparam int B_RUN      = 4;
   localparam int B_RST_EN   = 5;
   localparam int B_SCOPE    = 6;
   localparam int B_FAIL_EN  = 7;
   localparam int B_CLR_STAT = 8;
   localparam int B_CLR_CNT  = 9;
   localparam longint unsigned MAX_PERIOD_US = 64000000;

   // Period in microseconds for a code; codes 1..10 double from 1 ms.
   function automatic longint unsigned period_us(input logic [CODE_W-1:0] code);
      case (code)
         4'd0:    return 512;
         4'd11:   return 1000000;
         4'd12:   return 4000000;
         4'd13:   return 16000000;
         4'd14:   return 32000000;
         4'd15:   return 64000000;
         default: return longint'(1000) << (code - 4'd1);
      endcase
   endfunction
endpackage

// File: rtl/wdog_period_dec.sv
module wdog_period_dec
   import wdog_pkg::*;
#(
   parameter int CNT_W        = 26,
   parameter int TICKS_PER_US = 1
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  limit
);
   generate
      if (TICKS_PER_US == 1) begin : g_direct
         assign limit = CNT_W'(period_us(code));
      end else begin : g_scaled
         assign limit = CNT_W'(period_us(code) * longint'(TICKS_PER_US));
      end
   endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             hit
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic last;
   assign last = (count == limit - ONE);
   assign hit  = run && tick && !restart && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (restart || !run)     count <= '0;
      else if (tick)                count <= last ? '0 : count + ONE;
   end
endmodule

// File: rtl/wdog_actions.sv
module wdog_actions (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr_stat,
   input  logic rst_en,
   input  logic scope_sys,
   input  logic fail_en,
   output logic flag,
   output logic fail,
   output logic rst_local,
   output logic rst_sys
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag      <= 1'b0;
         fail      <= 1'b0;
         rst_local <= 1'b0;
         rst_sys   <= 1'b0;
      end else begin
         if (hit)           flag <= 1'b1;
         else if (clr_stat) flag <= 1'b0;
         if (hit && fail_en) fail <= 1'b1;
         else if (clr_stat)  fail <= 1'b0;
         rst_local <= hit && rst_en && !scope_sys;
         rst_sys   <= hit && rst_en &&  scope_sys;
      end
   end
endmodule

// File: rtl/wdog_sel_period.sv
module wdog_sel_period
   import wdog_pkg::*;
#(
   parameter int CNT_W        = 26,
   parameter int TICKS_PER_US = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 cfg_we_i,
   input  logic [CFG_W-1:0]     cfg_wdata_i,
   output logic                 timeout_o,
   output logic                 board_fail_o,
   output logic                 rst_local_o,
   output logic                 rst_sys_o,
   output logic [CNT_W-1:0]     count_o,
   output logic [CNT_W-1:0]     limit_o
);
   localparam longint unsigned MAX_TICKS = MAX_PERIOD_US * longint'(TICKS_PER_US);

   initial begin
      if (TICKS_PER_US < 1)
         $error("TICKS_PER_US must be at least 1");
      if (CNT_W > 62 || MAX_TICKS >= (longint'(1) << CNT_W))
         $error("CNT_W too narrow for the longest period");
   end

   logic [CODE_W-1:0] code_q;
   logic run_q, rst_en_q, scope_q, fail_en_q;
   logic restart, clr_stat, hit;

   assign restart  = cfg_we_i && (cfg_wdata_i[B_CLR_CNT] ||
                                  (cfg_wdata_i[CODE_W-1:0] != code_q));
   assign clr_stat = cfg_we_i && cfg_wdata_i[B_CLR_STAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q    <= '0;
         run_q     <= 1'b0;
         rst_en_q  <= 1'b0;
         scope_q   <= 1'b0;
         fail_en_q <= 1'b0;
      end else if (cfg_we_i) begin
         code_q    <= cfg_wdata_i[CODE_W-1:0];
         run_q     <= cfg_wdata_i[B_RUN];
         rst_en_q  <= cfg_wdata_i[B_RST_EN];
         scope_q   <= cfg_wdata_i[B_SCOPE];
         fail_en_q <= cfg_wdata_i[B_FAIL_EN];
      end
   end

   wdog_period_dec #(.CNT_W(CNT_W), .TICKS_PER_US(TICKS_PER_US)) u_dec (
      .code  (code_q),
      .limit (limit_o)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .tick    (tick_i),
      .restart (restart),
      .limit   (limit_o),
      .count   (count_o),
      .hit     (hit)
   );

   wdog_actions u_act (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .clr_stat  (clr_stat),
      .rst_en    (rst_en_q),
      .scope_sys (scope_q),
      .fail_en   (fail_en_q),
      .flag      (timeout_o),
      .fail      (board_fail_o),
      .rst_local (rst_local_o),
      .rst_sys   (rst_sys_o)
   );
endmodule

// File: rtl/wdog_sel_period_chk.sv
module wdog_sel_period_chk
   import wdog_pkg::*;
#(
   parameter int CNT_W = 26
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we_i,
   input logic [CFG_W-1:0] cfg_wdata_i,
   input logic             run_q,
   input logic             hit,
   input logic             timeout_o,
   input logic             board_fail_o,
   input logic             rst_local_o,
   input logic             rst_sys_o,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] limit_o
);
   a_r9_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
      count_o < limit_o);

   a_r3_idle_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> count_o == '0);

   a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rst_local_o, rst_sys_o}));

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_local_o || rst_sys_o) |=> !(rst_local_o || rst_sys_o));

   a_r6_pulse_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_local_o || rst_sys_o) |-> $past(hit));

   a_r7_fail_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      board_fail_o |-> timeout_o);

   a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o && !(cfg_we_i && cfg_wdata_i[B_CLR_STAT])) |=> timeout_o);

   a_r8_clear_unless_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && cfg_wdata_i[B_CLR_STAT] && !hit) |=> !timeout_o && !board_fail_o);
endmodule

bind wdog_sel_period wdog_sel_period_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we_i     (cfg_we_i),
   .cfg_wdata_i  (cfg_wdata_i),
   .run_q        (run_q),
   .hit          (hit),
   .timeout_o    (timeout_o),
   .board_fail_o (board_fail_o),
   .rst_local_o  (rst_local_o),
   .rst_sys_o    (rst_sys_o),
   .count_o      (count_o),
   .limit_o      (limit_o)
);

// File: tb/sim_wdog_sel_period.sv
module sim_wdog_sel_period;
   localparam int CNT_W = 26;
   localparam logic [15:0] RUN  = 16'h0010, RSTEN = 16'h0020, SCOPE = 16'h0040,
                           FAIL = 16'h0080, CLRS  = 16'h0100, CLRC  = 16'h0200;
   localparam int unsigned LIM_TAB [16] = '{
      512, 1000, 2000, 4000, 8000, 16000, 32000, 64000,
      128000, 256000, 512000, 1000000, 4000000, 16000000, 32000000, 64000000};

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
   logic [15:0] wdata = '0;
   logic tmo, bfail, rloc, rsys;
   logic [CNT_W-1:0] cnt, lim;
   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wdog_sel_period #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .cfg_we_i(we), .cfg_wdata_i(wdata),
      .timeout_o(tmo), .board_fail_o(bfail), .rst_local_o(rloc), .rst_sys_o(rsys),
      .count_o(cnt), .limit_o(lim));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] d);
      we = 1'b1; wdata = d; step(); we = 1'b0; wdata = '0;
   endtask

   task automatic tick_n(input int n);
      tick = 1'b1;
      for (int i = 0; i < n; i++) step();
      tick = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
      // R1 reset state
      chk("R1 timeout", 32'(tmo), 0);
      chk("R1 fail", 32'(bfail), 0);
      chk("R1 rst", 32'({rloc, rsys}), 0);
      chk("R1 count", 32'(cnt), 0);
      chk("R1 limit", 32'(lim), 512);

      // R2 decode table walk
      for (int c = 0; c < 16; c++) begin
         wr(16'(c));
         chk("R2 limit", 32'(lim), LIM_TAB[c]);
      end

      // R3 disabled: ticks ignored
      wr(16'h0000);
      tick_n(600);
      chk("R3 idle count", 32'(cnt), 0);
      chk("R3 idle timeout", 32'(tmo), 0);

      // R4, R6, R7, R9 on code 0 with local reset and fail
      wr(RUN | RSTEN | FAIL);
      tick_n(511);
      chk("R3 counts ticks", 32'(cnt), 511);
      chk("R4 no early timeout", 32'(tmo), 0);
      tick_n(1);
      chk("R4 timeout", 32'(tmo), 1);
      chk("R9 count wraps", 32'(cnt), 0);
      chk("R6 local pulse", 32'(rloc), 1);
      chk("R6 no sys", 32'(rsys), 0);
      chk("R7 fail set", 32'(bfail), 1);
      step();
      chk("R6 pulse ends", 32'(rloc), 0);
      chk("R7 fail held", 32'(bfail), 1);

      // R8 clear status
      wr(RUN | RSTEN | FAIL | CLRS);
      chk("R8 flag cleared", 32'(tmo), 0);
      chk("R8 fail cleared", 32'(bfail), 0);

      // R5 restarts
      tick_n(100);
      chk("R5 count runs", 32'(cnt), 100);
      wr(RUN | RSTEN | FAIL);
      chk("R5 plain write keeps count", 32'(cnt), 100);
      wr(RUN | RSTEN | FAIL | CLRC);
      chk("R5 clear count", 32'(cnt), 0);
      tick_n(50);
      wr(16'h0001 | RUN | RSTEN | SCOPE);
      chk("R5 code change restarts", 32'(cnt), 0);
      tick_n(999);
      chk("R4 code1 no early", 32'(tmo), 0);
      tick_n(1);
      chk("R4 code1 timeout", 32'(tmo), 1);
      chk("R6 sys pulse", 32'(rsys), 1);
      chk("R6 no local", 32'(rloc), 0);
      chk("R7 fail disabled", 32'(bfail), 0);

      // R6 reset disabled
      wr(RUN | CLRS);
      chk("R8 clear again", 32'(tmo), 0);
      tick_n(512);
      chk("R4 timeout no rst", 32'(tmo), 1);
      chk("R6 no pulse", 32'({rloc, rsys}), 0);

      // R8 timeout beats clear in same cycle
      wr(RUN | CLRS | CLRC);
      chk("R8 cleared", 32'(tmo), 0);
      tick_n(511);
      tick = 1'b1; we = 1'b1; wdata = RUN | CLRS;
      step();
      tick = 1'b0; we = 1'b0; wdata = '0;
      chk("R8 hit wins", 32'(tmo), 1);

      // R5 clear count beats tick
      wr(RUN | CLRS);
      tick_n(10);
      chk("R5 pre", 32'(cnt), 10);
      tick = 1'b1; we = 1'b1; wdata = RUN | CLRC;
      step();
      tick = 1'b0; we = 1'b0; wdata = '0;
      chk("R5 clear with tick", 32'(cnt), 0);

      // R3 disable stops everything
      wr(16'h0000);
      tick_n(2000);
      chk("R3 disabled count", 32'(cnt), 0);
      chk("R3 disabled timeout", 32'(tmo), 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule